// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and brings the memory from power-on to a usable state. After a synchronous reset it keeps the clock-enable pin low and the chip deselected for a stabilization interval. That interval is a count of clock cycles, derived from a clock frequency in MHz and a delay in microseconds. When the interval ends, the block issues a fixed list of commands on the command pins, one clock each, with only NOPs between them.

The list has three groups. The first is a bank precharge, the load of the extended mode register that enables the DLL, and a load of the base mode register with the DLL-reset bit set. The second is another precharge and two auto refreshes. The last is a reload of the base mode register with the DLL-reset bit cleared. The spacing between commands is set by cycle-count parameters for precharge, mode-register and refresh recovery. A separate guard counts the DLL lock interval from the DLL-reset load. The ready flag rises only after both the final load's recovery and that guard have expired. Burst length, burst type, CAS latency and output drive strength are parameters that are packed into the mode words.

Top module: `ddr_powerup_seq`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, and in the first cycle after it, `cke` is 0, `cs_n` is 1 and `init_done` is 0.
- R2: Let WAIT = CLK_MHZ*STABLE_US. For cycles 0 to WAIT-1 after reset, `cke` is 0 and {cs_n,ras_n,cas_n,we_n} = 1111 (deselect). In cycle WAIT, `cke` rises together with a NOP (0111), and `cke` stays 1 until the next reset.
- R3: After the NOP, the commands come in exactly this order: precharge, extended mode load, base mode load with DLL reset, precharge, auto refresh, auto refresh, base mode load without DLL reset. On {cs_n,ras_n,cas_n,we_n} the encodings are LOAD MODE = 0000, AUTO REFRESH = 0001, PRECHARGE = 0010 and NOP = 0111.
- R4: Every precharge drives `addr[10]`=1 (all banks), with `ba`=00 and all other address bits 0.
- R5: The extended mode load drives `ba`=01 and `addr` with bit 0 = 0 (DLL enabled), bit 1 = DRIVE_HALF and all other bits 0.
- R6: Both base mode loads drive `ba`=00 and `addr` with bits [2:0]=BL_CODE, bit 3=BURST_ILV and bits [6:4]=CL_CODE. Bit 8 (DLL reset) is 1 on the first load and 0 on the final load, and all other bits are 0.
- R7: A command occupies one cycle. From the NOP to the first precharge the spacing is 2 cycles. After a precharge the spacing is T_RP cycles, after a mode load T_MRD, and after an auto refresh T_RFC. Every other cycle with `cke`=1 is a NOP with `ba` and `addr` at 0.
- R8: `init_done` rises in cycle max(Tfinal+T_MRD, Tdll+DLL_LOCK), where Tfinal is the cycle of the final mode load and Tdll the cycle of the DLL-reset load. It then stays 1, with NOPs on the bus, until reset.
- R9: A reset asserted in the middle of the sequence returns the block to the R1 state, and the whole sequence of R2 to R8 then runs again from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address; selects the mode register on loads |
| addr | output | ADDR_W | Address; carries mode words and the all-bank bit |
| init_done | output | 1 | Memory ready for normal traffic |

## Verification
The hardest case to reach from the ports is the ready flag's dependence on two independent timers. Either the DLL lock guard or the command spacing chain can set the cycle in which `init_done` rises. The bench holds two instances that differ only in refresh recovery. In the first the 200-cycle lock guard is the later event, and in the second the long refresh spacing pushes the final load past the guard. The reset taken in the middle of the sequence is reached by pulsing reset a few cycles after the first precharge, so that R9 is checked against a complete second run.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    ST_WAIT, ST_NOP, ST_PRE1, ST_EMR, ST_MR_DLL,
    ST_PRE2, ST_REF1, ST_REF2, ST_MR_RUN, ST_DONE
  } step_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_LMR   = 4'b0000;
  localparam logic [3:0] CMD_REF   = 4'b0001;
  localparam logic [3:0] CMD_PRE   = 4'b0010;
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_DESEL = 4'b1111;

  localparam int NOP_SPACING = 2;

  function automatic int wait_cycles(input int mhz, input int us);
    return mhz * us;
  endfunction

  function automatic logic [15:0] base_mode_word(input logic [2:0] bl, input logic bt,
                                                 input logic [2:0] cl, input logic dll_rst);
    logic [15:0] w;
    w      = '0;
    w[2:0] = bl;
    w[3]   = bt;
    w[6:4] = cl;
    w[8]   = dll_rst;
    return w;
  endfunction

  function automatic logic [15:0] ext_mode_word(input logic drive_half);
    logic [15:0] w;
    w    = '0;
    w[0] = 1'b0;
    w[1] = drive_half;
    return w;
  endfunction

  function automatic step_t next_step(input step_t s);
    return (s == ST_DONE) ? ST_DONE : step_t'(s + 4'd1);
  endfunction

  // Cycles from this step's command to the next command
  function automatic int spacing(input step_t s, input int trp, input int tmrd, input int trfc);
    case (s)
      ST_NOP:                        return NOP_SPACING;
      ST_PRE1, ST_PRE2:              return trp;
      ST_EMR, ST_MR_DLL, ST_MR_RUN:  return tmrd;
      ST_REF1, ST_REF2:              return trfc;
      default:                       return 2;
    endcase
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int          W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= RST_VAL;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/ddr_dll_guard.sv
module ddr_dll_guard #(
  parameter int LOCK = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic locked
);
  localparam int CW = $clog2(LOCK + 1);

  logic [CW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (start) begin
      cnt   <= CW'(LOCK - 1);
      armed <= 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign locked = armed && (cnt == '0);
endmodule

// File: rtl/ddr_cmd_drive.sv
module ddr_cmd_drive
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  step_t             step,
  input  logic              issue,
  input  logic [ADDR_W-1:0] emr_word,
  input  logic [ADDR_W-1:0] mr_dll_word,
  input  logic [ADDR_W-1:0] mr_run_word,
  output logic              cke,
  output logic [3:0]        cmd_bits,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    cke      = (step != ST_WAIT);
    cmd_bits = (step == ST_WAIT) ? CMD_DESEL : CMD_NOP;
    ba       = 2'b00;
    addr     = '0;
    if (issue) begin
      case (step)
        ST_PRE1, ST_PRE2: begin
          cmd_bits = CMD_PRE;
          addr[10] = 1'b1;
        end
        ST_EMR: begin
          cmd_bits = CMD_LMR;
          ba       = 2'b01;
          addr     = emr_word;
        end
        ST_MR_DLL: begin
          cmd_bits = CMD_LMR;
          addr     = mr_dll_word;
        end
        ST_MR_RUN: begin
          cmd_bits = CMD_LMR;
          addr     = mr_run_word;
        end
        ST_REF1, ST_REF2: cmd_bits = CMD_REF;
        default:          cmd_bits = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/ddr_powerup_seq.sv
module ddr_powerup_seq
  import ddr_init_pkg::*;
#(
  parameter int         ADDR_W     = 13,
  parameter int         CLK_MHZ    = 250,
  parameter int         STABLE_US  = 200,
  parameter int         T_RP       = 3,
  parameter int         T_MRD      = 2,
  parameter int         T_RFC      = 18,
  parameter int         DLL_LOCK   = 200,
  parameter logic [2:0] BL_CODE    = 3'b011,
  parameter logic       BURST_ILV  = 1'b0,
  parameter logic [2:0] CL_CODE    = 3'b010,
  parameter logic       DRIVE_HALF = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);
  localparam int WAIT_CYC = wait_cycles(CLK_MHZ, STABLE_US);
  localparam int TMR_MAX  = WAIT_CYC + T_RP + T_MRD + T_RFC;
  localparam int TMR_W    = $clog2(TMR_MAX + 1);

  localparam logic [ADDR_W-1:0] EMR_W    = ADDR_W'(ext_mode_word(DRIVE_HALF));
  localparam logic [ADDR_W-1:0] MR_DLL_W = ADDR_W'(base_mode_word(BL_CODE, BURST_ILV, CL_CODE, 1'b1));
  localparam logic [ADDR_W-1:0] MR_RUN_W = ADDR_W'(base_mode_word(BL_CODE, BURST_ILV, CL_CODE, 1'b0));

  step_t            step;
  logic             in_gap;
  logic             cmd_issue;
  logic             dll_start;
  logic             dll_locked;
  logic             tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic [3:0]       cmd_bits;

  assign cmd_issue = !in_gap && (step != ST_DONE);
  assign dll_start = cmd_issue && (step == ST_MR_DLL);
  assign tmr_val   = TMR_W'(spacing(step, T_RP, T_MRD, T_RFC) - 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      step   <= ST_WAIT;
      in_gap <= 1'b1;
    end else if (in_gap && tmr_zero) begin
      step   <= next_step(step);
      in_gap <= 1'b0;
    end else if (cmd_issue) begin
      in_gap <= 1'b1;
    end
  end

  ddr_init_timer #(
    .W       (TMR_W),
    .RST_VAL (TMR_W'(WAIT_CYC - 1))
  ) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (cmd_issue),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  ddr_dll_guard #(.LOCK(DLL_LOCK)) u_dll (
    .clk    (clk),
    .rst    (rst),
    .start  (dll_start),
    .locked (dll_locked)
  );

  ddr_cmd_drive #(.ADDR_W(ADDR_W)) u_drv (
    .step        (step),
    .issue       (cmd_issue),
    .emr_word    (EMR_W),
    .mr_dll_word (MR_DLL_W),
    .mr_run_word (MR_RUN_W),
    .cke         (cke),
    .cmd_bits    (cmd_bits),
    .ba          (ba),
    .addr        (addr)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd_bits;
  assign init_done = (step == ST_DONE) && dll_locked;
endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [1:0]        ba,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done,
  input logic              dll_locked,
  input logic              cmd_issue
);
  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!cke && cs_n && !init_done));

  // R2
  cke_low_deselect_chk: assert property (@(posedge clk) disable iff (rst) !cke |-> cs_n);

  // R2
  cke_hold_chk: assert property (@(posedge clk) disable iff (rst) cke |=> cke);

  // R4
  pre_all_bank_chk: assert property (@(posedge clk) disable iff (rst)
    ({cs_n, ras_n, cas_n, we_n} == 4'b0010) |-> (addr[10] && ba == 2'b00));

  // R7
  single_cycle_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (cke && {cs_n, ras_n, cas_n, we_n} != 4'b0111) |=> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

  // R7
  issue_selects_chk: assert property (@(posedge clk) disable iff (rst) cmd_issue |-> !cs_n);

  // R8
  done_after_lock_chk: assert property (@(posedge clk) disable iff (rst) init_done |-> dll_locked);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst) init_done |=> init_done);
endmodule

bind ddr_powerup_seq ddr_init_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cke        (cke),
  .cs_n       (cs_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .ba         (ba),
  .addr       (addr),
  .init_done  (init_done),
  .dll_locked (dll_locked),
  .cmd_issue  (cmd_issue)
);

// File: tb/sim_ddr_powerup_seq.sv
module sim_ddr_powerup_seq;
  localparam int MHZ = 250, US = 2, TRP = 3, TMRD = 2, RFC0 = 9, RFC1 = 120, LOCK = 200;
  localparam int W = MHZ * US;
  localparam logic [2:0] BL = 3'b011, CL = 3'b010;
  localparam logic BT = 1'b1, DRV = 1'b1;

  logic clk = 0, rst = 1;
  always #2 clk = ~clk;

  logic cke0, cs0, ras0, cas0, we0, dn0, cke1, cs1, ras1, cas1, we1, dn1;
  logic [1:0] ba0, ba1;
  logic [12:0] a0, a1;

  ddr_powerup_seq #(.CLK_MHZ(MHZ), .STABLE_US(US), .T_RP(TRP), .T_MRD(TMRD), .T_RFC(RFC0),
    .DLL_LOCK(LOCK), .BL_CODE(BL), .BURST_ILV(BT), .CL_CODE(CL), .DRIVE_HALF(DRV)) u0 (
    .clk(clk), .rst(rst), .cke(cke0), .cs_n(cs0), .ras_n(ras0), .cas_n(cas0), .we_n(we0),
    .ba(ba0), .addr(a0), .init_done(dn0));

  ddr_powerup_seq #(.CLK_MHZ(MHZ), .STABLE_US(US), .T_RP(TRP), .T_MRD(TMRD), .T_RFC(RFC1),
    .DLL_LOCK(LOCK), .BL_CODE(BL), .BURST_ILV(BT), .CL_CODE(CL), .DRIVE_HALF(DRV)) u1 (
    .clk(clk), .rst(rst), .cke(cke1), .cs_n(cs1), .ras_n(ras1), .cas_n(cas1), .we_n(we1),
    .ba(ba1), .addr(a1), .init_done(dn1));

  int compared = 0, mismatched = 0, cyc = 0, total = 0;
  bit started = 0, second_run = 0;

  always @(posedge clk) begin
    total <= total + 1;
    if (rst) cyc <= 0; else cyc <= cyc + 1;
    if (rst) started <= 1;
  end

  function automatic int mode_val(input int dll);
    return int'(BL) + (int'(BT) << 3) + (int'(CL) << 4) + (dll << 8);
  endfunction

  // Expected {done,cke,cs,ras,cas,we,ba[1:0],a[12:0]} for cycle n
  function automatic logic [20:0] model(input int n, input int rfc, output string tag);
    int t_p1, t_e, t_m1, t_p2, t_r1, t_r2, t_m2, t_dn;
    logic dn;
    t_p1 = W + 2;     t_e  = t_p1 + TRP;  t_m1 = t_e + TMRD;  t_p2 = t_m1 + TMRD;
    t_r1 = t_p2 + TRP; t_r2 = t_r1 + rfc; t_m2 = t_r2 + rfc;
    t_dn = (t_m2 + TMRD > t_m1 + LOCK) ? t_m2 + TMRD : t_m1 + LOCK;
    dn = (n >= t_dn);
    tag = dn ? "R8 done" : "R7 nop gap";
    if (n == 0)                   begin tag = "R1 reset"; return {2'b00, 4'b1111, 15'd0}; end
    if (n < W)                    begin tag = "R2 wait";  return {2'b00, 4'b1111, 15'd0}; end
    if (n == W)                   begin tag = "R2 nop";   return {2'b01, 4'b0111, 15'd0}; end
    if (n == t_p1 || n == t_p2)   begin tag = "R4 pre";   return {2'b01, 4'b0010, 2'b00, 13'h400}; end
    if (n == t_e)                 begin tag = "R5 emr";   return {2'b01, 4'b0000, 2'b01, 13'(int'(DRV) << 1)}; end
    if (n == t_m1)                begin tag = "R6 mr dll"; return {2'b01, 4'b0000, 2'b00, 13'(mode_val(1))}; end
    if (n == t_m2)                begin tag = "R6 mr run"; return {2'b01, 4'b0000, 2'b00, 13'(mode_val(0))}; end
    if (n == t_r1 || n == t_r2)   begin tag = "R3 refresh"; return {2'b01, 4'b0001, 15'd0}; end
    return {dn, 1'b1, 4'b0111, 15'd0};
  endfunction

  task automatic compare(input int which, input logic [20:0] act, input int rfc);
    string tag;
    logic [20:0] exp;
    exp = model(cyc, rfc, tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s%s u%0d cyc %0d: actual %h expected %h",
               second_run ? "R9 " : "", tag, which, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      compare(0, {dn0, cke0, cs0, ras0, cas0, we0, ba0, a0}, RFC0);
      compare(1, {dn1, cke1, cs1, ras1, cas1, we1, ba1, a1}, RFC1);
    end
  end

  task automatic wait_cycles_tb(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        wait_cycles_tb(4);
        rst = 0;
        wait_cycles_tb(W + 20);          // mid-sequence, after first precharge
        rst = 1;
        second_run = 1;
        wait_cycles_tb(3);
        rst = 0;
        wait_cycles_tb(W + 400);         // both instances done and held
      end
      begin
        wait (total > 5000);
        mismatched++;
        $display("FAIL watchdog: actual %0d cycles expected below 5000", total);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule